// File: doc/BRIEF.md
# Strobe-Qualified Status Link

This block moves a two-bit status code from a sending clock domain to a receiving clock domain over three wires: two code lines and one valid strobe. Local logic in the sending domain raises a request with a new code. The sender lowers the strobe first. It then drives the new code and keeps the strobe low for a set number of settling clocks. After that it raises the strobe again.

The receiver brings all three wires into its own clock through multi-flop synchronisers. It takes the code only when the synchronised strobe rises. It holds the last code it took and gives a one-cycle update pulse each time it takes one. Because the code moves only while the strobe is low, the receiver never reports a half-changed code. Requests that arrive while an update is running are kept in a single pending slot, and a newer request replaces an older one.

Top module: `slink_top`

## Requirements
- R1: Status codes are two bits wide: 00 = Init, 01 = Ready, 10 = Busy, 11 = Error. The received status carries the same encoding as the request.
- R2: After reset, line_strobe_o is 1, line_code_o is 00, busy_o is 0, status_o is 00 and update_o is 0.
- R3: A request taken while idle makes the strobe go low on the next sender clock with the old code still driven. One clock later the new code appears. The strobe then stays low with the new code for SETTLE_CYCLES clocks (default 2) before it goes high.
- R4: line_code_o changes only on a sender clock where line_strobe_o is low both before and after the change.
- R5: The receiver passes every wire through a synchroniser of SYNC_STAGES flops (default 2). It updates status_o only on a rising edge of the synchronised strobe, and status_o changes at no other time.
- R6: A direct change such as 00 to 11 is reported as the final code only; no intermediate 01 or 10 is ever reported.
- R7: update_o pulses high for one receiver clock for every code taken, including a code equal to the one already held.
- R8: A request that arrives while an update is in progress is stored as pending and sent right after the current update. A later request overwrites an older pending one, so the dropped value is never sent.
- R9: busy_o goes high on the clock the strobe drops. It stays high until the strobe has been high again for one clock, then falls when the link is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx_i | input | 1 | Sender clock |
| clk_rx_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both sides |
| req_valid_i | input | 1 | One-cycle request strobe from local sender logic |
| req_code_i | input | 2 | Requested status code |
| busy_o | output | 1 | Sender update in progress |
| line_code_o | output | 2 | Code lines on the wire |
| line_strobe_o | output | 1 | Valid strobe on the wire |
| status_o | output | 2 | Last status taken by the receiver |
| update_o | output | 1 | One-cycle pulse per status taken |

## Verification
Two functions can fall on the same sender clock. One is a fresh request arriving while an update is still running. The other is the pending slot being overwritten or being emptied as the next sequence starts. The bench provokes this by sending three requests close together inside one busy window. It then checks two things: that the receiver reports only the first and the last value, and that the strobe rose exactly twice. A second overlap sits in the receiver, where a new strobe edge and an equal code must still produce an update pulse. The bench checks this by sending the same code twice and counting pulses.

// File: rtl/slink_pkg.sv
package slink_pkg;
  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_INIT  = 2'b00,
    ST_READY = 2'b01,
    ST_BUSY  = 2'b10,
    ST_ERROR = 2'b11
  } status_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_DROP,
    TX_SETTLE,
    TX_HOLD
  } tx_state_e;
endpackage

// File: rtl/slink_sync.sv
module slink_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slink_tx.sv
module slink_tx
  import slink_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] code_o,
  output logic              strobe_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  tx_state_e         state_q;
  logic [CODE_W-1:0] code_q, next_q, pend_q;
  logic              pend_vld_q, strobe_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      code_q     <= ST_INIT;
      next_q     <= ST_INIT;
      pend_q     <= ST_INIT;
      pend_vld_q <= 1'b0;
      strobe_q   <= 1'b1;
      cnt_q      <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (req_valid_i || pend_vld_q) begin
            // newest request wins over an older pending one
            next_q     <= req_valid_i ? req_code_i : pend_q;
            pend_vld_q <= 1'b0;
            strobe_q   <= 1'b0;
            state_q    <= TX_DROP;
          end
        end
        TX_DROP: begin
          code_q  <= next_q;
          cnt_q   <= '0;
          state_q <= TX_SETTLE;
        end
        TX_SETTLE: begin
          if (cnt_q == CNT_LAST) begin
            strobe_q <= 1'b1;
            state_q  <= TX_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        TX_HOLD: state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
      if (state_q != TX_IDLE && req_valid_i) begin
        pend_q     <= req_code_i;
        pend_vld_q <= 1'b1;
      end
    end
  end

  assign busy_o   = (state_q != TX_IDLE);
  assign code_o   = code_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/slink_rx.sv
module slink_rx
  import slink_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              strobe_i,
  output logic [CODE_W-1:0] status_o,
  output logic              update_o
);
  logic [CODE_W:0]   sync_d;
  logic [CODE_W:0]   sync_q;
  logic              stb_d_q, update_q;
  logic [CODE_W-1:0] status_q;

  assign sync_d = {strobe_i, code_i};

  // strobe resets high so release from reset shows no edge
  slink_sync #(
    .WIDTH  (CODE_W + 1),
    .STAGES (SYNC_STAGES),
    .RST_VAL({1'b1, {CODE_W{1'b0}}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_d_q  <= 1'b1;
      status_q <= ST_INIT;
      update_q <= 1'b0;
    end else begin
      stb_d_q  <= sync_q[CODE_W];
      update_q <= 1'b0;
      if (sync_q[CODE_W] && !stb_d_q) begin
        status_q <= sync_q[CODE_W-1:0];
        update_q <= 1'b1;
      end
    end
  end

  assign status_o = status_q;
  assign update_o = update_q;
endmodule

// File: rtl/slink_top.sv
module slink_top
  import slink_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_tx_i,
  input  logic       clk_rx_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_code_i,
  output logic       busy_o,
  output logic [1:0] line_code_o,
  output logic       line_strobe_o,
  output logic [1:0] status_o,
  output logic       update_o
);
  slink_tx #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_tx (
    .clk_i      (clk_tx_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_code_i (req_code_i),
    .busy_o     (busy_o),
    .code_o     (line_code_o),
    .strobe_o   (line_strobe_o)
  );

  slink_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i   (clk_rx_i),
    .rst_ni  (rst_ni),
    .code_i  (line_code_o),
    .strobe_i(line_strobe_o),
    .status_o(status_o),
    .update_o(update_o)
  );
endmodule

// File: rtl/slink_checker.sv
module slink_checker (
  input logic       clk_tx_i,
  input logic       clk_rx_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic [1:0] line_code_o,
  input logic       line_strobe_o,
  input logic [1:0] status_o,
  input logic       update_o
);
  a_r4_code_moves_under_low_strobe: assert property (
    @(posedge clk_tx_i) disable iff (!rst_ni)
      !$stable(line_code_o) |-> (!line_strobe_o && !$past(line_strobe_o)));

  a_r9_busy_covers_low_strobe: assert property (
    @(posedge clk_tx_i) disable iff (!rst_ni)
      !line_strobe_o |-> busy_o);

  a_r9_busy_after_rise: assert property (
    @(posedge clk_tx_i) disable iff (!rst_ni)
      $rose(line_strobe_o) |-> busy_o);

  a_r5_status_only_on_update: assert property (
    @(posedge clk_rx_i) disable iff (!rst_ni)
      !$stable(status_o) |-> update_o);

  a_r7_update_single_cycle: assert property (
    @(posedge clk_rx_i) disable iff (!rst_ni)
      update_o |=> !update_o);
endmodule

bind slink_top slink_checker u_slink_checker (
  .clk_tx_i     (clk_tx_i),
  .clk_rx_i     (clk_rx_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .line_code_o  (line_code_o),
  .line_strobe_o(line_strobe_o),
  .status_o     (status_o),
  .update_o     (update_o)
);

// File: tb/slink_top_bench.sv
`timescale 1ns/1ps
module slink_top_bench;
  logic       clk_tx_i = 1'b0, clk_rx_i = 1'b0, rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [1:0] req_code_i = 2'b00;
  logic       busy_o, line_strobe_o, update_o;
  logic [1:0] line_code_o, status_o;

  int checks = 0, failures = 0;
  logic [1:0] log_q [0:63];
  int log_n = 0;
  int rise_n = 0;
  int r4_viol = 0;
  int r5_viol = 0;
  logic prev_stb = 1'b1;
  logic [1:0] prev_code = 2'b00;
  logic [1:0] prev_status = 2'b00;

  always #10 clk_tx_i = ~clk_tx_i;  // 50 MHz
  always #7  clk_rx_i = ~clk_rx_i;

  slink_top u_slink_top (.*);

  always @(negedge clk_rx_i) begin
    if (rst_ni) begin
      if (update_o && log_n < 64) begin
        log_q[log_n] = status_o;
        log_n++;
      end
      if (status_o != prev_status && !update_o) r5_viol++;
      prev_status = status_o;
    end
  end

  always @(negedge clk_tx_i) begin
    if (rst_ni) begin
      if (line_code_o != prev_code && (prev_stb || line_strobe_o)) r4_viol++;
      if (line_strobe_o && !prev_stb) rise_n++;
      prev_code = line_code_o;
      prev_stb  = line_strobe_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c);
    @(negedge clk_tx_i);
    req_valid_i = 1'b1;
    req_code_i  = c;
    @(negedge clk_tx_i);
    req_valid_i = 1'b0;
  endtask

  task automatic settle_rx();
    repeat (16) @(negedge clk_tx_i);
  endtask

  task automatic t_reset();
    chk(line_strobe_o == 1'b1, "R2 strobe", line_strobe_o, 1);
    chk(line_code_o == 2'b00, "R2 code", line_code_o, 0);
    chk(busy_o == 1'b0, "R2 busy", busy_o, 0);
    chk(status_o == 2'b00, "R2 status", status_o, 0);
    chk(update_o == 1'b0, "R2 update", update_o, 0);
  endtask

  task automatic t_single_timing();
    int base;
    base = log_n;
    send(2'b01);
    chk(!line_strobe_o && line_code_o == 2'b00, "R3 drop with old code", line_code_o, 0);
    chk(busy_o, "R9 busy at drop", busy_o, 1);
    @(negedge clk_tx_i);
    chk(!line_strobe_o && line_code_o == 2'b01, "R3 new code under low strobe", line_code_o, 1);
    @(negedge clk_tx_i);
    chk(!line_strobe_o, "R3 strobe low during settle", line_strobe_o, 0);
    @(negedge clk_tx_i);
    chk(line_strobe_o, "R3 strobe rises after settle", line_strobe_o, 1);
    chk(busy_o, "R9 busy held one clock after rise", busy_o, 1);
    @(negedge clk_tx_i);
    chk(!busy_o, "R9 busy clears", busy_o, 0);
    settle_rx();
    chk(status_o == 2'b01, "R1 status Ready", status_o, 1);
    chk(log_n - base == 1, "R7 one update", log_n - base, 1);
  endtask

  task automatic t_direct_jump();
    int base;
    send(2'b00);
    settle_rx();
    base = log_n;
    send(2'b11);
    settle_rx();
    chk(log_n - base == 1, "R6 single report on 00->11", log_n - base, 1);
    chk(log_q[base] == 2'b11, "R6 reported code", log_q[base], 3);
    chk(status_o == 2'b11, "R1 status Error", status_o, 3);
  endtask

  task automatic t_same_code();
    int base;
    base = log_n;
    send(2'b11);
    settle_rx();
    chk(log_n - base == 1, "R7 pulse on equal code", log_n - base, 1);
    chk(status_o == 2'b11, "R7 status kept", status_o, 3);
  endtask

  task automatic t_queue();
    int base, rb;
    base = log_n;
    rb   = rise_n;
    send(2'b10);
    send(2'b00);
    send(2'b01);
    settle_rx();
    settle_rx();
    chk(log_n - base == 2, "R8 two updates", log_n - base, 2);
    chk(log_q[base] == 2'b10, "R8 first value", log_q[base], 2);
    chk(log_q[base+1] == 2'b01, "R8 latest pending wins", log_q[base+1], 1);
    chk(rise_n - rb == 2, "R8 strobe rises twice", rise_n - rb, 2);
    chk(status_o == 2'b01, "R8 final status", status_o, 1);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_tx_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_tx_i);
    t_reset();
    t_single_timing();
    t_direct_jump();
    t_same_code();
    t_queue();
    chk(r4_viol == 0, "R4 code change with strobe high", r4_viol, 0);
    chk(r5_viol == 0, "R5 status change without update", r5_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule